// File: doc/BRIEF.md
# Bus-Master DMA Control Registers

This block holds the host-facing control state of one bus-master disk DMA channel. Software reaches it through a dword-wide register port with byte enables. There are three registers: a command byte, a status byte and a descriptor-table pointer. The block drives a run level, a transfer direction and the table address to a separate DMA engine. It collects completion, error and device-interrupt events from that engine and from the drive, and it raises a level interrupt toward the host.

Software follows a fixed sequence. It loads the table pointer and the direction, and it clears any stale error and interrupt flags. It issues the command to the drive, and only then sets the run bit. When the device interrupt arrives, it reads the status. A clean finish shows interrupt set, error clear and active clear. Software then acknowledges the interrupt by writing one to the flag. The status byte mixes three kinds of bit: an activity flag that software cannot write, two sticky flags that a write of one clears, and two drive-capability bits that software reads and writes freely.

Top module: `bmdma_ctrl`

## Requirements
- R1: After reset, both register words read 0, and `dma_run`, `dma_to_mem` and `host_irq` are 0.
- R2: The command byte is byte lane 0 of word 0. Bit 0 is the run bit and drives `dma_run`. Bit 3 is the direction bit and drives `dma_to_mem`, where 1 means the device writes into memory. Every other command bit reads 0.
- R3: The status byte is byte lane 2 of word 0, which is read data bits 23:16. Its bit 0 is the active flag. A status write has no effect on the active flag, and the active flag is never 1 while the run bit is 0.
- R4: A write that changes the run bit from 0 to 1 sets the active flag on the same clock edge. A write of 1 while the run bit is already 1 leaves the active flag as it is.
- R5: The active flag clears on the edge where `eng_done` or `eng_err` is high, or where a write changes the run bit from 1 to 0.
- R6: `eng_err` sets status bit 1 (error) and `dev_irq` sets status bit 2 (interrupt). Both flags stay set until software clears them.
- R7: A status write with bit 1 or bit 2 set to 1 clears that flag, and a 0 in those positions leaves it unchanged. If a set event arrives on the same edge as the clearing write, the flag stays set.
- R8: Status bits 5 and 6 are plain read/write capability flags for drive 0 and drive 1. Status bits 3, 4 and 7 read 0.
- R9: Word 1 is the 32-bit descriptor-table pointer. Each byte is written under its own byte enable. Bits 1:0 always read 0, and the stored value appears on `dma_table_addr`.
- R10: `host_irq` equals status bit 2. It stays high until software clears the flag.
- R11: A write has no effect on a byte lane whose enable is 0, and it has no effect on the unmapped lanes 1 and 3 of word 0.
- R12: After a clean transfer that ends with `dev_irq` and `eng_done`, status bits 2:0 read 100b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_word | input | WORD_AW | Word index, used for both read and write (0 = command/status, 1 = pointer) |
| reg_be | input | DATA_W/8 | Byte enables for the write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the selected word, combinational |
| eng_done | input | 1 | Engine reached the end of the descriptor table |
| eng_err | input | 1 | Engine reports a transfer error |
| dev_irq | input | 1 | Interrupt from the drive |
| dma_run | output | 1 | Run level to the engine |
| dma_to_mem | output | 1 | Direction: 1 = device to memory |
| dma_table_addr | output | DATA_W | Descriptor-table base address |
| host_irq | output | 1 | Level interrupt to the host |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, a one-bit word index and two forced-zero pointer bits. With these values the bench can reach the whole map, both words and all four byte lanes, including the unmapped lanes. It can also drive events and clearing writes on the same edge, so the cases where a set and a clear collide are tested directly. A behavioural model, updated on every edge, predicts every output and the read data of whichever word is selected.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  // Bit positions inside the command byte
  localparam int CMD_RUN_BIT = 0;
  localparam int CMD_DIR_BIT = 3;
  // Bit positions inside the status byte
  localparam int ST_ACT_BIT  = 0;
  localparam int ST_ERR_BIT  = 1;
  localparam int ST_IRQ_BIT  = 2;
  localparam int ST_CAP0_BIT = 5;
  localparam int ST_CAP1_BIT = 6;
  // Byte lanes of the control word
  localparam int CMD_LANE    = 0;
  localparam int STAT_LANE   = 2;

  // Next value of a sticky flag: a set event wins over a write-one clear
  function automatic logic sticky_next(input logic cur, input logic set_ev,
                                       input logic clr_wr);
    return set_ev | (cur & ~clr_wr);
  endfunction

  // Next value of the activity flag
  function automatic logic active_next(input logic cur, input logic run_rise,
                                       input logic stop_ev);
    if (run_rise) return 1'b1;
    if (stop_ev)  return 1'b0;
    return cur;
  endfunction

  // Command byte as software reads it back
  function automatic logic [7:0] cmd_view(input logic run, input logic dir);
    logic [7:0] b;
    b = 8'h00;
    b[CMD_RUN_BIT] = run;
    b[CMD_DIR_BIT] = dir;
    return b;
  endfunction

  // Status byte as software reads it back
  function automatic logic [7:0] stat_view(input logic act, input logic err,
                                           input logic irq, input logic [1:0] cap);
    logic [7:0] b;
    b = 8'h00;
    b[ST_ACT_BIT]  = act;
    b[ST_ERR_BIT]  = err;
    b[ST_IRQ_BIT]  = irq;
    b[ST_CAP0_BIT] = cap[0];
    b[ST_CAP1_BIT] = cap[1];
    return b;
  endfunction
endpackage

// File: rtl/bmdma_cmd_reg.sv
module bmdma_cmd_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic run_in,
  input  logic dir_in,
  output logic run_q,
  output logic dir_q,
  output logic run_rise,
  output logic run_fall
);
  assign run_rise = wr_en &  run_in & ~run_q;
  assign run_fall = wr_en & ~run_in &  run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      dir_q <= 1'b0;
    end else if (wr_en) begin
      run_q <= run_in;
      dir_q <= dir_in;
    end
  end

  // R2
  run_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_rise |=> run_q);
  // R2
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(dir_q));
endmodule

// File: rtl/bmdma_stat_reg.sv
module bmdma_stat_reg
  import bmdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       clr_err,
  input  logic       clr_irq,
  input  logic [1:0] cap_in,
  input  logic       run_lvl,
  input  logic       run_rise,
  input  logic       run_fall,
  input  logic       eng_done,
  input  logic       eng_err,
  input  logic       dev_irq,
  output logic       act_q,
  output logic       err_q,
  output logic       irq_q,
  output logic [1:0] cap_q
);
  logic stop_ev;
  logic err_clr_wr;
  logic irq_clr_wr;

  assign stop_ev    = eng_done | eng_err | run_fall;
  assign err_clr_wr = wr_en & clr_err;
  assign irq_clr_wr = wr_en & clr_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      err_q <= 1'b0;
      irq_q <= 1'b0;
      cap_q <= '0;
    end else begin
      act_q <= active_next(act_q, run_rise, stop_ev);
      err_q <= sticky_next(err_q, eng_err, err_clr_wr);
      irq_q <= sticky_next(irq_q, dev_irq, irq_clr_wr);
      if (wr_en) cap_q <= cap_in;
    end
  end

  // R3
  act_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> run_lvl);
  // R4
  act_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_rise |=> act_q);
  // R5
  act_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && !run_rise) |=> !act_q);
  // R6
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_irq |=> irq_q);
  // R7
  irq_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> $past(irq_clr_wr));
  // R8
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cap_q));
endmodule

// File: rtl/bmdma_ptr_reg.sv
module bmdma_ptr_reg #(
  parameter int PTR_W      = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [PTR_W/8-1:0] be,
  input  logic [PTR_W-1:0]   wdata,
  output logic [PTR_W-1:0]   ptr
);
  localparam int NB = PTR_W / 8;
  logic [PTR_W-1:0] raw_q;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                raw_q[g*8 +: 8] <= 8'h00;
      else if (wr_en && be[g])   raw_q[g*8 +: 8] <= wdata[g*8 +: 8];
    end
  end

  assign ptr = {raw_q[PTR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ptr));
endmodule

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
  import bmdma_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int WORD_AW    = 1,
  parameter int ALIGN_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [WORD_AW-1:0]  reg_word,
  input  logic [DATA_W/8-1:0] reg_be,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                eng_done,
  input  logic                eng_err,
  input  logic                dev_irq,
  output logic                dma_run,
  output logic                dma_to_mem,
  output logic [DATA_W-1:0]   dma_table_addr,
  output logic                host_irq
);
  localparam int BE_W = DATA_W / 8;
  localparam logic [WORD_AW-1:0] CTRL_WORD = WORD_AW'(0);
  localparam logic [WORD_AW-1:0] PTR_WORD  = WORD_AW'(1);
  localparam int CMD_LSB  = CMD_LANE * 8;
  localparam int STAT_LSB = STAT_LANE * 8;

  // Decoded write events, named for the checkers
  logic ctrl_sel, ptr_sel;
  logic cmd_wr, stat_wr, ptr_wr;
  logic run_q, dir_q, run_rise, run_fall;
  logic act_q, err_q, irq_q;
  logic [1:0] cap_q;
  logic [7:0] cmd_byte, stat_byte;

  assign ctrl_sel = (reg_word == CTRL_WORD);
  assign ptr_sel  = (reg_word == PTR_WORD);
  assign cmd_wr   = reg_wr & ctrl_sel & reg_be[CMD_LANE];
  assign stat_wr  = reg_wr & ctrl_sel & reg_be[STAT_LANE];
  assign ptr_wr   = reg_wr & ptr_sel;

  bmdma_cmd_reg u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cmd_wr),
    .run_in   (reg_wdata[CMD_LSB + CMD_RUN_BIT]),
    .dir_in   (reg_wdata[CMD_LSB + CMD_DIR_BIT]),
    .run_q    (run_q),
    .dir_q    (dir_q),
    .run_rise (run_rise),
    .run_fall (run_fall)
  );

  bmdma_stat_reg u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (stat_wr),
    .clr_err  (reg_wdata[STAT_LSB + ST_ERR_BIT]),
    .clr_irq  (reg_wdata[STAT_LSB + ST_IRQ_BIT]),
    .cap_in   ({reg_wdata[STAT_LSB + ST_CAP1_BIT], reg_wdata[STAT_LSB + ST_CAP0_BIT]}),
    .run_lvl  (run_q),
    .run_rise (run_rise),
    .run_fall (run_fall),
    .eng_done (eng_done),
    .eng_err  (eng_err),
    .dev_irq  (dev_irq),
    .act_q    (act_q),
    .err_q    (err_q),
    .irq_q    (irq_q),
    .cap_q    (cap_q)
  );

  bmdma_ptr_reg #(.PTR_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (ptr_wr),
    .be    (reg_be),
    .wdata (reg_wdata),
    .ptr   (dma_table_addr)
  );

  assign cmd_byte  = cmd_view(run_q, dir_q);
  assign stat_byte = stat_view(act_q, err_q, irq_q, cap_q);

  always_comb begin
    reg_rdata = '0;
    if (ctrl_sel) begin
      reg_rdata[CMD_LSB  +: 8] = cmd_byte;
      reg_rdata[STAT_LSB +: 8] = stat_byte;
    end else if (ptr_sel) begin
      reg_rdata = dma_table_addr;
    end
  end

  assign dma_run    = run_q;
  assign dma_to_mem = dir_q;
  assign host_irq   = irq_q;

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq && !stat_wr) |=> host_irq);
  // R11
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && ctrl_sel && !reg_be[CMD_LANE] && !reg_be[STAT_LANE])
      |=> ($stable(dma_run) && $stable(dma_to_mem)));
endmodule

// File: tb/bmdma_ctrl_tb.sv
module bmdma_ctrl_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [0:0]  reg_word = 0;
  logic [3:0]  reg_be = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        eng_done = 0, eng_err = 0, dev_irq = 0;
  logic        dma_run, dma_to_mem, host_irq;
  logic [31:0] dma_table_addr;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit finished = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_run, m_dir, m_act, m_err, m_irq, m_cap0, m_cap1;
  logic [31:0] m_ptr;

  always #5 clk = ~clk;

  bmdma_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_word(reg_word),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_done(eng_done), .eng_err(eng_err), .dev_irq(dev_irq),
    .dma_run(dma_run), .dma_to_mem(dma_to_mem),
    .dma_table_addr(dma_table_addr), .host_irq(host_irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_dir = 0; m_act = 0; m_err = 0; m_irq = 0;
      m_cap0 = 0; m_cap1 = 0; m_ptr = 0;
    end else begin
      int new_run;
      bit w0, w1;
      w0 = reg_wr && reg_word == 0;
      w1 = reg_wr && reg_word == 1;
      new_run = (w0 && reg_be[0]) ? int'(reg_wdata[0]) : m_run;
      if (m_run == 0 && new_run == 1) m_act = 1;
      else if (eng_done || eng_err || (m_run == 1 && new_run == 0)) m_act = 0;
      if (w0 && reg_be[0]) m_dir = reg_wdata[3];
      m_run = new_run;
      if (eng_err) m_err = 1;
      else if (w0 && reg_be[2] && reg_wdata[17]) m_err = 0;
      if (dev_irq) m_irq = 1;
      else if (w0 && reg_be[2] && reg_wdata[18]) m_irq = 0;
      if (w0 && reg_be[2]) begin m_cap0 = reg_wdata[21]; m_cap1 = reg_wdata[22]; end
      for (int i = 0; i < 4; i++)
        if (w1 && reg_be[i]) m_ptr[i*8 +: 8] = reg_wdata[i*8 +: 8];
      m_ptr[1:0] = 2'b00;
    end
  end

  function automatic logic [31:0] model_word(input logic w);
    logic [31:0] v;
    if (w) return m_ptr;
    v = 0;
    v[0] = m_run[0]; v[3] = m_dir[0];
    v[16] = m_act[0]; v[17] = m_err[0]; v[18] = m_irq[0];
    v[21] = m_cap0[0]; v[22] = m_cap1[0];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always begin
    @(posedge clk); #3;
    if (started && rst_n && !finished) begin
      chk({cur_req, " rdata"}, reg_rdata, model_word(reg_word[0]));
      chk("R2 dma_run", {31'b0, dma_run}, m_run);
      chk("R2 dma_to_mem", {31'b0, dma_to_mem}, m_dir);
      chk("R9 dma_table_addr", dma_table_addr, m_ptr);
      chk("R10 host_irq", {31'b0, host_irq}, m_irq);
    end
  end

  task automatic cyc(input bit wr, input bit w, input logic [3:0] be,
                     input logic [31:0] d, input bit dn, input bit er, input bit ir);
    @(negedge clk);
    reg_wr = wr; reg_word = w; reg_be = be; reg_wdata = d;
    eng_done = dn; eng_err = er; dev_irq = ir;
    @(negedge clk);
    reg_wr = 0; reg_be = 0; eng_done = 0; eng_err = 0; dev_irq = 0;
  endtask

  task automatic rd(input bit w, input logic [31:0] exp, input string tag);
    reg_word = w;
    @(posedge clk); #3;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    started = 1;
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    rd(0, 32'h0, "R1 word0");
    rd(1, 32'h0, "R1 word1");
    chk("R1 irq", {31'b0, host_irq}, 0);

    cur_req = "R9";
    cyc(1, 1, 4'hF, 32'h1234_5677, 0, 0, 0);
    rd(1, 32'h1234_5674, "R9 full write");
    cyc(1, 1, 4'b0010, 32'hAABB_CCDD, 0, 0, 0);
    rd(1, 32'h1234_CC74, "R9 byte write");

    cur_req = "R2";
    cyc(1, 0, 4'b0001, 32'h0000_0008, 0, 0, 0);
    rd(0, 32'h0000_0008, "R2 dir only");
    chk("R2 run low", {31'b0, dma_run}, 0);
    cur_req = "R4";
    cyc(1, 0, 4'b0001, 32'h0000_00FF, 0, 0, 0);
    rd(0, 32'h0001_0009, "R4 start sets active");

    cur_req = "R3";
    cyc(1, 0, 4'b0100, 32'h0, 0, 0, 0);
    rd(0, 32'h0001_0009, "R3 active not writable");
    cur_req = "R4";
    cyc(1, 0, 4'b0001, 32'h0000_0009, 0, 0, 0);
    rd(0, 32'h0001_0009, "R4 rewrite keeps active");

    cur_req = "R12";
    cyc(0, 0, 4'b0, 32'h0, 1, 0, 1);
    rd(0, 32'h0004_0009, "R12 clean end");
    chk("R12 low bits", {29'b0, reg_rdata[18:16]}, 32'h4);
    chk("R10 irq high", {31'b0, host_irq}, 1);

    cur_req = "R7";
    cyc(1, 0, 4'b0100, 32'h0002_0000, 0, 0, 0);
    rd(0, 32'h0004_0009, "R7 zero leaves irq");
    cyc(1, 0, 4'b0100, 32'h0004_0000, 0, 0, 0);
    rd(0, 32'h0000_0009, "R7 one clears irq");
    chk("R10 irq low", {31'b0, host_irq}, 0);

    cur_req = "R6";
    cyc(1, 0, 4'b0001, 32'h0000_0008, 0, 0, 0);
    cyc(1, 0, 4'b0001, 32'h0000_0001, 0, 0, 0);
    rd(0, 32'h0001_0001, "R6 restart");
    cyc(0, 0, 4'b0, 32'h0, 0, 1, 0);
    rd(0, 32'h0002_0001, "R6 error sets, active clears");
    cur_req = "R7";
    cyc(1, 0, 4'b0100, 32'h0004_0000, 0, 0, 1);
    rd(0, 32'h0006_0001, "R7 set wins over clear");
    cyc(1, 0, 4'b0100, 32'h0006_0000, 0, 0, 0);
    rd(0, 32'h0000_0001, "R7 clear both");

    cur_req = "R5";
    cyc(1, 0, 4'b0001, 32'h0, 0, 0, 0);
    cyc(1, 0, 4'b0001, 32'h1, 0, 0, 0);
    rd(0, 32'h0001_0001, "R5 active before stop");
    cyc(1, 0, 4'b0001, 32'h0, 0, 0, 0);
    rd(0, 32'h0000_0000, "R5 stop clears active");

    cur_req = "R8";
    cyc(1, 0, 4'b0100, 32'h00F8_0000, 0, 0, 0);
    rd(0, 32'h0060_0000, "R8 cap bits set, others zero");
    cyc(1, 0, 4'b0100, 32'h0020_0000, 0, 0, 0);
    rd(0, 32'h0020_0000, "R8 cap bit 6 cleared");

    cur_req = "R11";
    cyc(1, 0, 4'b0000, 32'hFFFF_FFFF, 0, 0, 0);
    rd(0, 32'h0020_0000, "R11 no enables");
    cyc(1, 0, 4'b1010, 32'hFFFF_FFFF, 0, 0, 0);
    rd(0, 32'h0020_0000, "R11 unmapped lanes");
    chk("R11 run unchanged", {31'b0, dma_run}, 0);
    cyc(1, 1, 4'b0000, 32'hFFFF_FFFF, 0, 0, 0);
    rd(1, 32'h1234_CC74, "R11 pointer no enables");

    cur_req = "R9";
    cyc(1, 1, 4'hF, 32'hFFFF_FFFF, 0, 0, 0);
    rd(1, 32'hFFFF_FFFC, "R9 low bits zero");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule